// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources of a peripheral into one active-low request line. Each source owns a sticky flag that a one-cycle event pulse sets and that stays set until software or a per-source clear strobe removes it. A matching mask bit, held in a separate enable register that the processor writes, decides whether a pending flag reaches the request output.

The processor sees both registers through one small port, selected by `cpu_sel`. Reading the flag register gives the seven flags plus a summary bit at the top, so one read tells whether this peripheral has anything pending. Writing the flag register acknowledges flags. Writing the enable register uses its top bit to pick set or clear for the ones in the lower bits. The request output is driven to both levels at all times and is never left floating.

Top module: `intr_aggregator`

## Requirements
- R1: After reset every flag and every enable bit is 0, `irq_n` is 1, a flag read (`cpu_sel`=0) returns 0x00 and an enable read (`cpu_sel`=1) returns 0x80.
- R2: A 1 on `evt_set[i]` at a clock edge sets flag i; the flag stays 1 on later cycles with no event until it is cleared.
- R3: A 1 on `evt_clr[i]` at a clock edge clears flag i and leaves every other flag as it was.
- R4: A write with `cpu_sel`=0 clears each flag whose bit in `cpu_wdata[6:0]` is 1, leaves flags at a 0 bit unchanged, and ignores `cpu_wdata[7]`.
- R5: When flag i is set by `evt_set[i]` and cleared by a strobe or a write in the same cycle, the flag ends up 1.
- R6: A write with `cpu_sel`=1 and `cpu_wdata[7]`=1 sets each enable bit whose bit in `cpu_wdata[6:0]` is 1; other enable bits keep their value.
- R7: A write with `cpu_sel`=1 and `cpu_wdata[7]`=0 clears each enable bit whose bit in `cpu_wdata[6:0]` is 1; other enable bits keep their value.
- R8: An enable read returns the seven enable bits in bits 6..0 and a 1 in bit 7.
- R9: A flag read returns the seven flags in bits 6..0 and, in bit 7, 1 exactly when at least one flag is 1.
- R10: `irq_n` is 0 exactly when some flag i and enable bit i are both 1, and 1 otherwise, following register changes in the same cycle they happen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_set | input | 7 | Per-source set pulses |
| evt_clr | input | 7 | Per-source clear strobes |
| cpu_sel | input | 1 | Register select: 0 flags, 1 enables |
| cpu_we | input | 1 | Write strobe for the selected register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Interrupt request, active low, push-pull |

## Verification
Directed patterns first raise flags with the mask closed, which separates flag storage from request gating, then open and close single mask bits so that a wrong set/clear decode of the enable write shows up as a request that should not move. Flag acknowledgements are tried with the top data bit set and with zero bits beside ones, telling a correct per-bit clear from a whole-register clear. Collisions of a set pulse with a strobe and with a write show the priority, and a long stretch of random mixed traffic against a bench model covers combinations the directed cases miss.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int IRQ_SRC_N = 7;
  localparam int IRQ_REG_W = IRQ_SRC_N + 1;

  typedef logic [IRQ_SRC_N-1:0] src_vec_t;
  typedef logic [IRQ_REG_W-1:0] reg_word_t;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  // Next mask value: top bit of the written word picks set or clear.
  function automatic src_vec_t mask_update(input src_vec_t cur,
                                           input reg_word_t wd);
    src_vec_t pick;
    pick = wd[IRQ_SRC_N-1:0];
    if (wd[IRQ_REG_W-1]) mask_update = cur | pick;
    else                 mask_update = cur & ~pick;
  endfunction

  // Flag view with the summary bit on top.
  function automatic reg_word_t flag_view(input src_vec_t fl);
    flag_view = {|fl, fl};
  endfunction

  // Mask view: top bit always reads as one.
  function automatic reg_word_t mask_view(input src_vec_t en);
    mask_view = {1'b1, en};
  endfunction

  function automatic logic any_active(input src_vec_t fl, input src_vec_t en);
    any_active = |(fl & en);
  endfunction
endpackage

// File: rtl/intr_flag_cell.sv
module intr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set has priority over any clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/intr_enable_reg.sv
module intr_enable_reg
  import intr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  reg_word_t wdata_i,
  output src_vec_t  en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= mask_update(en_o, wdata_i);
  end
endmodule

// File: rtl/intr_read_drive.sv
module intr_read_drive
  import intr_pkg::*;
(
  input  logic      sel_i,
  input  src_vec_t  flag_i,
  input  src_vec_t  en_i,
  output reg_word_t rdata_o,
  output logic      irq_n_o
);
  always_comb begin
    if (sel_i == SEL_ENABLE) rdata_o = mask_view(en_i);
    else                     rdata_o = flag_view(flag_i);
  end

  // Driven to both levels, never released.
  assign irq_n_o = ~any_active(flag_i, en_i);
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_pkg::*;
#(
  parameter int SRC_N = IRQ_SRC_N,
  localparam int REG_W = SRC_N + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] evt_set,
  input  logic [SRC_N-1:0] evt_clr,
  input  logic             cpu_sel,
  input  logic             cpu_we,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  output logic             irq_n
);
  // Named internal events, visible to the bound checker.
  logic             flag_wr;
  logic             en_wr;
  logic [SRC_N-1:0] flag_wr_clr;
  logic [SRC_N-1:0] flag_clr_all;
  logic [SRC_N-1:0] flag_q;
  logic [SRC_N-1:0] en_q;

  assign flag_wr      = cpu_we && (cpu_sel == SEL_FLAGS);
  assign en_wr        = cpu_we && (cpu_sel == SEL_ENABLE);
  assign flag_wr_clr  = flag_wr ? cpu_wdata[SRC_N-1:0] : '0;
  assign flag_clr_all = flag_wr_clr | evt_clr;

  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    intr_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_set[i]),
      .clr_i (flag_clr_all[i]),
      .q_o   (flag_q[i])
    );
  end

  intr_enable_reg u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (cpu_wdata),
    .en_o    (en_q)
  );

  intr_read_drive u_rd (
    .sel_i   (cpu_sel),
    .flag_i  (flag_q),
    .en_i    (en_q),
    .rdata_o (cpu_rdata),
    .irq_n_o (irq_n)
  );
endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk #(
  parameter int SRC_N = 7,
  localparam int REG_W = SRC_N + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] evt_set,
  input logic [SRC_N-1:0] evt_clr,
  input logic             cpu_sel,
  input logic             cpu_we,
  input logic [REG_W-1:0] cpu_wdata,
  input logic [REG_W-1:0] cpu_rdata,
  input logic             irq_n,
  input logic [SRC_N-1:0] flag_q,
  input logic [SRC_N-1:0] en_q,
  input logic [SRC_N-1:0] flag_wr_clr
);
  // R2 R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flag_q & $past(evt_set)) == $past(evt_set)));

  // R3 R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|((evt_clr | flag_wr_clr) & ~evt_set)) |=>
      ((flag_q & $past((evt_clr | flag_wr_clr) & ~evt_set)) == '0));

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set == '0 && evt_clr == '0 && flag_wr_clr == '0) |=> $stable(flag_q));

  // R6 R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_sel) |=> $stable(en_q));

  // R8
  mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sel |-> cpu_rdata[REG_W-1]);

  // R9
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_sel |-> (cpu_rdata[REG_W-1] == (flag_q != '0)));

  // R10
  req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) != '0) |-> (irq_n == 1'b0));

  // R10
  req_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & en_q) == '0) |-> (irq_n == 1'b1));
endmodule

bind intr_aggregator intr_aggregator_chk #(.SRC_N(SRC_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_set     (evt_set),
  .evt_clr     (evt_clr),
  .cpu_sel     (cpu_sel),
  .cpu_we      (cpu_we),
  .cpu_wdata   (cpu_wdata),
  .cpu_rdata   (cpu_rdata),
  .irq_n       (irq_n),
  .flag_q      (flag_q),
  .en_q        (en_q),
  .flag_wr_clr (flag_wr_clr)
);

// File: tb/intr_aggregator_bench.sv
`timescale 1ns/1ps
module intr_aggregator_bench;
  localparam int N = 7;

  typedef struct {
    logic [7:0] rdata;
    logic       irqn;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] evt_set = '0;
  logic [6:0] evt_clr = '0;
  logic       cpu_sel = 1'b0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       irq_n;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  // bench model, kept bit by bit
  bit m_flag[N];
  bit m_en[N];

  always #2.5 clk = ~clk;

  intr_aggregator u_intr_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] model_read(bit sel);
    logic [7:0] r;
    bit any;
    any = 0;
    for (int i = 0; i < N; i++) begin
      r[i] = sel ? m_en[i] : m_flag[i];
      if (m_flag[i]) any = 1;
    end
    r[7] = sel ? 1'b1 : any;
    return r;
  endfunction

  function automatic bit model_irqn();
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_en[i]) return 1'b0;
    return 1'b1;
  endfunction

  // Driver: one cycle of stimulus, model update, expectation pushed.
  task automatic step(input logic [6:0] s, input logic [6:0] c,
                      input bit we, input bit sel, input logic [7:0] wd,
                      input string tag);
    exp_t e;
    @(negedge clk);
    evt_set = s; evt_clr = c; cpu_we = we; cpu_sel = sel; cpu_wdata = wd;
    for (int i = 0; i < N; i++) begin
      if (s[i]) m_flag[i] = 1;
      else if (c[i] || (we && !sel && wd[i])) m_flag[i] = 0;
      if (we && sel && wd[i]) m_en[i] = wd[7];
    end
    e.rdata = model_read(sel);
    e.irqn  = model_irqn();
    e.tag   = tag;
    q.push_back(e);
  endtask

  // Monitor: compare one item after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (cpu_rdata !== e.rdata || irq_n !== e.irqn) begin
          n_fail++;
          $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
                   e.tag, cpu_rdata, irq_n, e.rdata, e.irqn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: done=0 expected done=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_en[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, both views
    step(7'h00, 7'h00, 0, 0, 8'h00, "R1 flags");
    step(7'h00, 7'h00, 0, 1, 8'h00, "R1 R8 enables");
    // R2 R9 flags rise with mask closed, request stays high (R10)
    step(7'h05, 7'h00, 0, 0, 8'h00, "R2 R9 set");
    step(7'h00, 7'h00, 0, 0, 8'h00, "R2 sticky");
    step(7'h00, 7'h00, 0, 0, 8'h00, "R10 masked");
    // R6 mask set bit0 -> request low
    step(7'h00, 7'h00, 1, 1, 8'h81, "R6 R10 set en0");
    step(7'h00, 7'h00, 1, 1, 8'h84, "R6 set en2 keep en0");
    // R7 clear en0 only
    step(7'h00, 7'h00, 1, 1, 8'h01, "R7 clear en0");
    // R3 strobe clears flag2, request goes high
    step(7'h00, 7'h04, 0, 0, 8'h00, "R3 R10 strobe");
    // R4 write ones elsewhere plus bit7: flag0 untouched
    step(7'h00, 7'h00, 1, 0, 8'hFE, "R4 other bits");
    step(7'h00, 7'h00, 1, 0, 8'h01, "R4 R9 clear flag0");
    // R5 collisions
    step(7'h40, 7'h40, 0, 0, 8'h00, "R5 set vs strobe");
    step(7'h02, 7'h00, 1, 0, 8'h02, "R5 set vs write");
    // all sources
    step(7'h7F, 7'h00, 0, 0, 8'h00, "R2 all");
    step(7'h00, 7'h00, 1, 1, 8'hFF, "R6 R10 all en");
    step(7'h00, 7'h00, 1, 1, 8'h7F, "R7 R10 none en");
    step(7'h00, 7'h7F, 0, 0, 8'h00, "R3 R9 clear all");
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[6:0] & r[13:7], r[20:14], r[21], r[22], r[30:23],
           "mix R2 R3 R4 R5 R6 R7 R10");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule